// File: doc/BRIEF.md
# Storage Channel Mode and Reset Controller

This block is the control-register logic for a group of storage channels. Each channel is either in direct register mode or in packet mode. It also holds a 64-bit packet base address and a packet size exponent. Software launches a packet by writing a fixed command word to a channel's command register. The channel then switches to packet mode and gives the packet engine a one-cycle start pulse. The channel goes back to register mode when the engine reports completion, when software writes the register-mode bit, when the channel logic is reset, or when the global reset is written.

All channels share one simple register bus. Address bits above the channel stride select the channel, and the bits below it select the register inside that channel's window. Reads are registered and return one cycle after the read strobe. Reading a control register returns the live mode and error state, so software can use the read to flush posted writes. Packet execution, the physical link and the taskfile registers are handled elsewhere. This block only drives start and link-reset pulses to them and takes done and error pulses back.

Top module: `chan_mode_ctrl`

## Requirements
- R1: After reset every channel is in register mode with its error flag clear, base address 0 and size exponent 6, and no start or link-reset pulse is asserted.
- R2: Writing 0x107 to a channel's command register (offset 0x200) while that channel is in register mode sets packet mode and asserts that channel's start output for exactly one cycle, in the cycle after the write.
- R3: A command write of any other value, or a write of 0x107 while the channel is already in packet mode, produces no start pulse and leaves the mode unchanged.
- R4: A done pulse from the engine while the channel is in packet mode returns the channel to register mode in the following cycle.
- R5: Writing control register 0 (offset 0x100) with bit 1 set forces register mode. A write with bit 1 clear leaves the mode unchanged.
- R6: An error pulse from the engine sets the channel's error flag. Writing control register 0 with bit 2 set clears it, but an error pulse in the same cycle wins and the flag stays set.
- R7: Writing control register 1 (offset 0x104) with bit 4 set resets the channel logic. The channel enters register mode and its error flag clears.
- R8: Writing control register 1 with bit 1 set asserts that channel's link-reset output for exactly one cycle and leaves the mode unchanged.
- R9: The low half of the base address is written and read at offset 0x300 and the high half at offset 0x304. Both halves appear on the channel's 64-bit base output.
- R10: The size exponent is written and read at offset 0x308 and holds the low 4 bits of the written word. It drives the channel's size output.
- R11: Channel n owns addresses n*0x4000 through n*0x4000+0x3FFF. A write in one channel's window changes no other channel, and offset 0x004 in any window other than window 0 has no effect.
- R12: Writing a word with bit 0 set to address 0x0004 resets every channel (register mode, error flag clear). Writing it with bit 0 clear does nothing.
- R13: Reading control register 0 returns bit 1 = 1 in register mode and bit 3 = error flag, with all other bits 0. Reads return data in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | Byte address (channel in the top two bits) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pkt_done | input | 4 | Per-channel packet completion pulse |
| pkt_err | input | 4 | Per-channel error pulse |
| pkt_start | output | 4 | Per-channel one-cycle packet start pulse |
| link_reset | output | 4 | Per-channel one-cycle link reset request |
| pkt_mode | output | 4 | Per-channel packet-mode flag |
| pkt_base | output | 256 | Per-channel 64-bit packet base address |
| pkt_sep | output | 16 | Per-channel 4-bit size exponent |

## Verification
The bench steps through every channel in turn. It checks that a second run command in packet mode does not start the engine a second time; a design that got this wrong would restart a packet already in progress. It drives an error pulse in the same cycle as a clear-error write, because a design that lets the clear win would lose an error. After each write it compares the state of all four channels, which exposes decode faults that touch the wrong channel. It also writes the global-reset offset inside window 1 and writes the global register with bit 0 clear, which catches a decoder that ignores the channel bits or the data bit.

// File: rtl/chan_pkg.sv
// Shared constants for the channel controller: register selects, offsets,
// control bit positions and the run command word.
package chan_pkg;
    typedef enum logic [2:0] {
        RS_NONE, RS_CTL0, RS_CTL1, RS_CMD, RS_BLO, RS_BHI, RS_SEP, RS_GLB
    } reg_sel_e;

    localparam int OFF_GLB  = 'h004;
    localparam int OFF_CTL0 = 'h100;
    localparam int OFF_CTL1 = 'h104;
    localparam int OFF_CMD  = 'h200;
    localparam int OFF_BLO  = 'h300;
    localparam int OFF_BHI  = 'h304;
    localparam int OFF_SEP  = 'h308;

    localparam int RUN_CODE     = 'h107;
    localparam int B_REGMODE    = 1;
    localparam int B_CLRERR     = 2;
    localparam int B_ERR_RD     = 3;
    localparam int B_LINKRST    = 1;
    localparam int B_CHANRST    = 4;
    localparam int B_GLBRST     = 0;
endpackage

// File: rtl/chan_addr_dec.sv
// Address decoder: splits a bus address into a channel index and a register
// select. Assumes NCH is a power of two and every offset fits the stride.
module chan_addr_dec
    import chan_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int STRIDE_LOG2 = 14,
    localparam int CH_W       = $clog2(NCH),
    localparam int ADDR_W     = STRIDE_LOG2 + CH_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch,
    output reg_sel_e          sel
);
    logic [STRIDE_LOG2-1:0] off;

    assign ch  = addr[ADDR_W-1:STRIDE_LOG2];
    assign off = addr[STRIDE_LOG2-1:0];

    // Map the in-window offset to a register select; global only in window 0.
    always_comb begin
        sel = RS_NONE;
        if      (off == STRIDE_LOG2'(OFF_CTL0)) sel = RS_CTL0;
        else if (off == STRIDE_LOG2'(OFF_CTL1)) sel = RS_CTL1;
        else if (off == STRIDE_LOG2'(OFF_CMD))  sel = RS_CMD;
        else if (off == STRIDE_LOG2'(OFF_BLO))  sel = RS_BLO;
        else if (off == STRIDE_LOG2'(OFF_BHI))  sel = RS_BHI;
        else if (off == STRIDE_LOG2'(OFF_SEP))  sel = RS_SEP;
        else if (off == STRIDE_LOG2'(OFF_GLB) && ch == '0) sel = RS_GLB;
    end
endmodule

// File: rtl/chan_unit.sv
// One channel: mode flag, error flag, base address and size exponent, plus
// start and link-reset pulses. Assumes wr is already qualified to this
// channel, and that glb_rst is a one-cycle pulse.
module chan_unit
    import chan_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SEP_W   = 4,
    parameter int SEP_RST = 6,
    localparam int BASE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              glb_rst,
    input  logic              done_i,
    input  logic              err_i,
    output logic              start_o,
    output logic              link_rst_o,
    output logic              pkt_mode_o,
    output logic [BASE_W-1:0] base_o,
    output logic [SEP_W-1:0]  sep_o,
    output logic [DATA_W-1:0] rd_o
);
    logic              pkt_mode_q, err_q;
    logic [DATA_W-1:0] base_lo, base_hi;
    logic [SEP_W-1:0]  sep_q;
    logic wr_ctl0, wr_ctl1, wr_cmd, chan_clr, force_reg, run_ok;

    assign wr_ctl0   = wr && sel == RS_CTL0;
    assign wr_ctl1   = wr && sel == RS_CTL1;
    assign wr_cmd    = wr && sel == RS_CMD;
    assign chan_clr  = glb_rst || (wr_ctl1 && wdata[B_CHANRST]);
    assign force_reg = chan_clr || (wr_ctl0 && wdata[B_REGMODE]);
    assign run_ok    = wr_cmd && wdata == DATA_W'(RUN_CODE) && !pkt_mode_q;

    // Mode flag: forced back to register mode, set by run, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)         pkt_mode_q <= 1'b0;
        else if (force_reg) pkt_mode_q <= 1'b0;
        else if (run_ok)    pkt_mode_q <= 1'b1;
        else if (done_i)    pkt_mode_q <= 1'b0;
    end

    // One-cycle start and link-reset pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o    <= 1'b0;
            link_rst_o <= 1'b0;
        end else begin
            start_o    <= run_ok && !force_reg;
            link_rst_o <= wr_ctl1 && wdata[B_LINKRST];
        end
    end

    // Error flag: reset clears, a new error beats a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_clr)                   err_q <= 1'b0;
        else if (err_i)                           err_q <= 1'b1;
        else if (wr_ctl0 && wdata[B_CLRERR])      err_q <= 1'b0;
    end

    // Base address halves and size exponent registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo <= '0;
            base_hi <= '0;
            sep_q   <= SEP_W'(SEP_RST);
        end else if (wr) begin
            if (sel == RS_BLO) base_lo <= wdata;
            if (sel == RS_BHI) base_hi <= wdata;
            if (sel == RS_SEP) sep_q   <= wdata[SEP_W-1:0];
        end
    end

    // Read-back value for the selected register.
    always_comb begin
        rd_o = '0;
        case (sel)
            RS_CTL0: begin
                rd_o[B_REGMODE] = !pkt_mode_q;
                rd_o[B_ERR_RD]  = err_q;
            end
            RS_BLO:  rd_o = base_lo;
            RS_BHI:  rd_o = base_hi;
            RS_SEP:  rd_o[SEP_W-1:0] = sep_q;
            default: rd_o = '0;
        endcase
    end

    assign pkt_mode_o = pkt_mode_q;
    assign base_o     = {base_hi, base_lo};
    assign sep_o      = sep_q;

    assert_start_from_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!$past(pkt_mode_q) && pkt_mode_q));
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && pkt_mode_q) |=> !start_o);
    assert_done_exits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_mode_q && done_i) |=> !pkt_mode_q);
    assert_err_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !chan_clr) |=> err_q);
    assert_chan_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clr |=> (!pkt_mode_q && !err_q && !start_o));
    assert_link_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_rst_o |=> !link_rst_o);
endmodule

// File: rtl/chan_mode_ctrl.sv
// Top: decodes the shared register bus, instantiates one chan_unit per
// channel, produces the global reset pulse and registers read data.
// Assumes NCH is a power of two and at most one strobe per cycle is useful.
module chan_mode_ctrl
    import chan_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int STRIDE_LOG2 = 14,
    parameter int DATA_W      = 32,
    parameter int SEP_W       = 4,
    parameter int SEP_RST     = 6,
    localparam int CH_W       = $clog2(NCH),
    localparam int ADDR_W     = STRIDE_LOG2 + CH_W,
    localparam int BASE_W     = 2 * DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NCH-1:0]         pkt_done,
    input  logic [NCH-1:0]         pkt_err,
    output logic [NCH-1:0]         pkt_start,
    output logic [NCH-1:0]         link_reset,
    output logic [NCH-1:0]         pkt_mode,
    output logic [NCH*BASE_W-1:0]  pkt_base,
    output logic [NCH*SEP_W-1:0]   pkt_sep
);
    logic [CH_W-1:0]   ch;
    reg_sel_e          sel;
    logic              glb_rst;
    logic [DATA_W-1:0] rd_arr [NCH];

    chan_addr_dec #(.NCH(NCH), .STRIDE_LOG2(STRIDE_LOG2)) u_dec (
        .addr(bus_addr), .ch(ch), .sel(sel)
    );

    assign glb_rst = bus_wr && sel == RS_GLB && bus_wdata[B_GLBRST];

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic wr_i;
        assign wr_i = bus_wr && ch == CH_W'(i);
        chan_unit #(.DATA_W(DATA_W), .SEP_W(SEP_W), .SEP_RST(SEP_RST)) u_unit (
            .clk(clk), .rst_n(rst_n), .wr(wr_i), .sel(sel), .wdata(bus_wdata),
            .glb_rst(glb_rst), .done_i(pkt_done[i]), .err_i(pkt_err[i]),
            .start_o(pkt_start[i]), .link_rst_o(link_reset[i]),
            .pkt_mode_o(pkt_mode[i]), .base_o(pkt_base[i*BASE_W +: BASE_W]),
            .sep_o(pkt_sep[i*SEP_W +: SEP_W]), .rd_o(rd_arr[i])
        );
    end

    // Registered read data from the addressed channel.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_arr[ch];
    end

    assert_start_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pkt_start));
    assert_global_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        glb_rst |=> (pkt_mode == '0 && pkt_start == '0));
endmodule

// File: tb/chan_mode_ctrl_test.sv
module chan_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
    logic [15:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [3:0]  pkt_done = 0, pkt_err = 0, pkt_start, link_reset, pkt_mode;
    logic [255:0] pkt_base;
    logic [15:0] pkt_sep;

    int checks = 0, failures = 0;
    logic [63:0] exp_base [NCH];
    logic [3:0]  exp_sep  [NCH];

    chan_mode_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic pulse_done(input int c);
        @(negedge clk); pkt_done[c] = 1;
        @(negedge clk); pkt_done[c] = 0;
    endtask

    task automatic pulse_err(input int c);
        @(negedge clk); pkt_err[c] = 1;
        @(negedge clk); pkt_err[c] = 0;
    endtask

    task automatic chk_all_cfg(input string req);
        for (int k = 0; k < NCH; k++) begin
            chk(req, pkt_base[k*64 +: 64], exp_base[k]);
            chk(req, 64'(pkt_sep[k*4 +: 4]), 64'(exp_sep[k]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 mode", 64'(pkt_mode), 0);
        chk("R1 start", 64'(pkt_start), 0);
        chk("R1 link", 64'(link_reset), 0);
        for (int c = 0; c < NCH; c++) begin
            exp_base[c] = 0; exp_sep[c] = 4'd6;
            rd(16'(c * 'h4000 + 'h100), d); chk("R1 ctl0", 64'(d), 64'h2);
            rd(16'(c * 'h4000 + 'h308), d); chk("R1 sep", 64'(d), 64'd6);
        end
        chk_all_cfg("R1 cfg");

        for (int c = 0; c < NCH; c++) begin
            w = 16'(c * 'h4000);
            // R9 / R11: base halves, other channels untouched
            exp_base[c] = {32'h5A00_0000 + 32'(c), 32'hC0DE_0000 + 32'(c * 3)};
            wr(w + 16'h300, exp_base[c][31:0]);
            wr(w + 16'h304, exp_base[c][63:32]);
            chk_all_cfg("R9 R11 base");
            rd(w + 16'h300, d); chk("R9 lo read", 64'(d), 64'(exp_base[c][31:0]));
            rd(w + 16'h304, d); chk("R9 hi read", 64'(d), 64'(exp_base[c][63:32]));
            // R10: size exponent, low 4 bits kept
            exp_sep[c] = 4'(c + 9);
            wr(w + 16'h308, 32'hFFFF_FFF0 | 32'(c + 9));
            chk_all_cfg("R10 R11 sep");
            rd(w + 16'h308, d); chk("R10 read", 64'(d), 64'(exp_sep[c]));
            // R3: wrong command value
            wr(w + 16'h200, 32'h106);
            chk("R3 bad cmd start", 64'(pkt_start), 0);
            chk("R3 bad cmd mode", 64'(pkt_mode), 0);
            // R2: run
            wr(w + 16'h200, 32'h107);
            chk("R2 start", 64'(pkt_start), 64'(1 << c));
            chk("R2 mode", 64'(pkt_mode), 64'(1 << c));
            @(negedge clk);
            chk("R2 single", 64'(pkt_start), 0);
            rd(w + 16'h100, d); chk("R13 ctl0 pkt", 64'(d), 0);
            // R3: run again in packet mode
            wr(w + 16'h200, 32'h107);
            chk("R3 restart", 64'(pkt_start), 0);
            chk("R3 mode kept", 64'(pkt_mode), 64'(1 << c));
            // R8: link reset in packet mode
            wr(w + 16'h104, 32'h2);
            chk("R8 pulse", 64'(link_reset), 64'(1 << c));
            chk("R8 mode kept", 64'(pkt_mode), 64'(1 << c));
            @(negedge clk);
            chk("R8 single", 64'(link_reset), 0);
            // R4: done
            pulse_done(c);
            chk("R4 done", 64'(pkt_mode), 0);
            // R5: reg-mode bit
            wr(w + 16'h200, 32'h107);
            wr(w + 16'h100, 32'h0);
            chk("R5 no bit", 64'(pkt_mode), 64'(1 << c));
            wr(w + 16'h100, 32'h2);
            chk("R5 forced", 64'(pkt_mode), 0);
            // R6 / R13: error flag
            pulse_err(c);
            rd(w + 16'h100, d); chk("R6 R13 err set", 64'(d), 64'hA);
            wr(w + 16'h100, 32'h4);
            rd(w + 16'h100, d); chk("R6 cleared", 64'(d), 64'h2);
            @(negedge clk); bus_wr = 1; bus_addr = w + 16'h100; bus_wdata = 32'h4; pkt_err[c] = 1;
            @(negedge clk); bus_wr = 0; pkt_err[c] = 0;
            rd(w + 16'h100, d); chk("R6 err wins", 64'(d), 64'hA);
            // R7: channel reset
            wr(w + 16'h200, 32'h107);
            wr(w + 16'h104, 32'h10);
            chk("R7 mode", 64'(pkt_mode), 0);
            chk("R7 link", 64'(link_reset), 0);
            rd(w + 16'h100, d); chk("R7 ctl0", 64'(d), 64'h2);
        end

        // R11: offset 0x004 in window 1 is not global
        wr(16'h0200, 32'h107);
        wr(16'h4004, 32'h1);
        chk("R11 fake global", 64'(pkt_mode), 64'h1);
        // R12: global reset with bit 0 clear does nothing
        wr(16'h4200, 32'h107);
        wr(16'h0004, 32'h0);
        chk("R12 bit clear", 64'(pkt_mode), 64'h3);
        wr(16'h8200, 32'h107);
        wr(16'hC200, 32'h107);
        pulse_err(0);
        pulse_err(3);
        wr(16'h0004, 32'h1);
        chk("R12 all reg", 64'(pkt_mode), 0);
        for (int c = 0; c < NCH; c++) begin
            rd(16'(c * 'h4000 + 'h100), d); chk("R12 ctl0", 64'(d), 64'h2);
        end
        chk_all_cfg("R12 cfg kept");
        // R4: done in register mode is ignored
        pulse_done(1);
        chk("R4 idle done", 64'(pkt_mode), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule